// File: doc/BRIEF.md
# Genlocked Frame Buffer Address Sequencer

This block produces the memory addresses for one video DMA pair. A producer channel stores incoming frames and a consumer channel fetches stored frames, both sharing a ring of three frame stores whose base addresses are held in small registers. A single frame-sync pulse, common to every channel in the system, moves both channels to the next store at once. The consumer always trails the producer by exactly one store, so the two never touch the same frame buffer and the memory traffic pattern stays deterministic.

Within a frame each channel walks a raster of lines. Each line starts on a power-of-two stride boundary, and each line's payload (7680 bytes by default: 1920 pixels of 4 bytes in an 8 KB stride, 1080 lines per frame, stores on 16 MB boundaries) is covered by bursts of up to 32 beats of 4 bytes. The final burst of a line is shortened so the payload is covered exactly. A downstream DMA engine pulses a step input each time it issues the presented burst; the sequencer then presents the next one.

Top module: `fb_addr_seq`

## Requirements
- R1: After reset the producer frame index is 1, the consumer index is 0, every base register is zero, both channels present line 0 offset 0 with the frame-done flag low.
- R2: While running, each frame-sync pulse advances both frame indices by one, wrapping from 2 back to 0; the new index shows in the cycle after the pulse.
- R3: The consumer frame index always equals the producer index minus one, modulo three.
- R4: A frame-sync pulse restarts a channel at line 0 offset 0 with frame-done cleared, even when the frame in progress is incomplete.
- R5: Each presented address equals the base of the channel's current store plus line number times the line stride (512 bytes in the small test configuration, 8 KB by default) plus the byte offset within the line.
- R6: A step pulse advances the offset by one burst (128 bytes); the burst whose remaining payload is at most 128 bytes is flagged as line end, reports remaining bytes divided by 4 as its beat count, and a step on it moves to offset 0 of the next line. Other bursts report 32 beats.
- R7: A step on the line-end burst of the last line raises frame-done; while frame-done is high, step pulses have no effect on the presented address.
- R8: A base register write (select 0 to 2) takes effect only while halted and only when the low alignment bits (24 by default) of the data are zero; any other write, or a select of 3, leaves all bases unchanged.
- R9: While halted, frame-sync and step pulses are ignored, the frame indices hold, and both channels are held at line 0 offset 0 with frame-done low.
- R10: The two channels walk independently: a step on one channel does not move the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High to run, low to halt |
| frame_sync | input | 1 | Shared frame-sync pulse |
| cfg_we | input | 1 | Base register write strobe |
| cfg_sel | input | 2 | Base register select (0 to 2) |
| cfg_data | input | 32 | Base register write data |
| wr_step | input | 1 | Producer burst issued |
| rd_step | input | 1 | Consumer burst issued |
| wr_addr | output | 32 | Producer burst address |
| wr_beats | output | 6 | Producer burst length in beats |
| wr_line_end | output | 1 | Producer burst is last of its line |
| wr_frame_done | output | 1 | Producer finished the frame |
| wr_frame_idx | output | 2 | Producer frame store index |
| rd_addr | output | 32 | Consumer burst address |
| rd_beats | output | 6 | Consumer burst length in beats |
| rd_line_end | output | 1 | Consumer burst is last of its line |
| rd_frame_done | output | 1 | Consumer finished the frame |
| rd_frame_idx | output | 2 | Consumer frame store index |

## Verification
A reduced raster (3 lines of 320 bytes in a 512-byte stride, 128-byte bursts) is walked to completion on each channel alone, which separates a shared position counter from independent ones and exposes the shortened 64-byte final burst and the hold after frame end. Sweeps with the two channels stepping at different cadences and frame-sync pulses arriving mid-line, mid-frame and back to back distinguish restart and ring-wrap errors from stride or offset errors. Base writes that are misaligned, aimed at the unused select, or issued while running are each followed by addresses from every store, so an accepted illegal write shows as a wrong base.

// File: rtl/fb_seq_pkg.sv
package fb_seq_pkg;

  // Channel slots inside the sequencer
  localparam int CH_PROD = 0;
  localparam int CH_CONS = 1;
  localparam int NUM_CH  = 2;

  // Index width that stays at least one bit wide
  function automatic int safe_clog2(input int value);
    int w;
    w = $clog2(value);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/fb_base_regs.sv
module fb_base_regs
  import fb_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_FRAMES = 3,
  parameter int ALIGN_LOG2 = 24,
  localparam int SEL_W     = safe_clog2(NUM_FRAMES),
  localparam int SLOTS     = 1 << SEL_W,
  localparam int HI_W      = ADDR_W - ALIGN_LOG2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    halted,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [ADDR_W-1:0]       cfg_data,
  output logic [SLOTS*ADDR_W-1:0] base_flat
);

  logic sel_valid;
  logic data_aligned;
  logic wr_ok;

  always_comb begin
    sel_valid    = ({1'b0, cfg_sel} < (SEL_W+1)'(NUM_FRAMES));
    data_aligned = (cfg_data[ALIGN_LOG2-1:0] == '0);
    wr_ok        = cfg_we && halted && sel_valid && data_aligned;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_FRAMES) begin : g_live
      logic [HI_W-1:0] hi_q;
      logic [HI_W-1:0] hi_d;
      logic            hi_en;

      always_comb begin
        hi_en = wr_ok && (cfg_sel == SEL_W'(g));
        hi_d  = cfg_data[ADDR_W-1:ALIGN_LOG2];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q <= '0;
        end else if (hi_en) begin
          hi_q <= hi_d;
        end
      end

      assign base_flat[g*ADDR_W +: ADDR_W] = {hi_q, {ALIGN_LOG2{1'b0}}};
    end else begin : g_pad
      assign base_flat[g*ADDR_W +: ADDR_W] = '0;
    end
  end

endmodule

// File: rtl/fb_frame_ring.sv
module fb_frame_ring
  import fb_seq_pkg::*;
#(
  parameter int NUM_FRAMES = 3,
  parameter int RESET_IDX  = 0,
  localparam int IDX_W     = safe_clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (adv) begin
      if (idx_q == IDX_W'(NUM_FRAMES - 1)) begin
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_W'(RESET_IDX);
    end else begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/fb_line_walker.sv
module fb_line_walker
  import fb_seq_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LINE_BYTES    = 7680,
  parameter int STRIDE_LOG2   = 13,
  parameter int LINES         = 1080,
  parameter int BURST_BYTES   = 128,
  parameter int BEAT_BYTES    = 4,
  localparam int OFF_W        = safe_clog2(LINE_BYTES),
  localparam int LINE_W       = safe_clog2(LINES),
  localparam int MAX_BEATS    = BURST_BYTES / BEAT_BYTES,
  localparam int BEAT_W       = safe_clog2(MAX_BEATS + 1),
  localparam int BEAT_SH      = $clog2(BEAT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr,
  output logic [BEAT_W-1:0] beats,
  output logic              line_end,
  output logic              frame_done
);

  localparam logic [OFF_W:0]    LINE_BYTES_C = (OFF_W+1)'(LINE_BYTES);
  localparam logic [OFF_W:0]    BURST_C      = (OFF_W+1)'(BURST_BYTES);
  localparam logic [LINE_W-1:0] LAST_LINE_C  = LINE_W'(LINES - 1);

  logic [OFF_W-1:0]  off_q,  off_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              done_q, done_d;
  logic              pos_en;

  logic [OFF_W:0]    remain;
  logic              last_burst;
  logic [OFF_W:0]    burst_bytes_now;

  always_comb begin
    remain          = LINE_BYTES_C - {1'b0, off_q};
    last_burst      = (remain <= BURST_C);
    burst_bytes_now = last_burst ? remain : BURST_C;
  end

  // Next-position logic
  always_comb begin
    off_d  = off_q;
    line_d = line_q;
    done_d = done_q;
    pos_en = 1'b0;
    if (!run || restart) begin
      off_d  = '0;
      line_d = '0;
      done_d = 1'b0;
      pos_en = 1'b1;
    end else if (step && !done_q) begin
      pos_en = 1'b1;
      if (last_burst) begin
        if (line_q == LAST_LINE_C) begin
          done_d = 1'b1;
        end else begin
          line_d = line_q + 1'b1;
          off_d  = '0;
        end
      end else begin
        off_d = off_q + OFF_W'(BURST_BYTES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      line_q <= '0;
      done_q <= 1'b0;
    end else if (pos_en) begin
      off_q  <= off_d;
      line_q <= line_d;
      done_q <= done_d;
    end
  end

  logic [ADDR_W-1:0] line_part;

  always_comb begin
    line_part  = ADDR_W'(line_q) << STRIDE_LOG2;
    addr       = base + line_part + ADDR_W'(off_q);
    beats      = BEAT_W'(burst_bytes_now >> BEAT_SH);
    line_end   = last_burst;
    frame_done = done_q;
  end

endmodule

// File: rtl/fb_addr_seq.sv
module fb_addr_seq
  import fb_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_FRAMES  = 3,
  parameter int ALIGN_LOG2  = 24,
  parameter int LINE_BYTES  = 7680,
  parameter int STRIDE_LOG2 = 13,
  parameter int LINES       = 1080,
  parameter int BURST_BYTES = 128,
  parameter int BEAT_BYTES  = 4,
  localparam int SEL_W      = safe_clog2(NUM_FRAMES),
  localparam int SLOTS      = 1 << SEL_W,
  localparam int BEAT_W     = safe_clog2(BURST_BYTES / BEAT_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              frame_sync,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              wr_step,
  input  logic              rd_step,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BEAT_W-1:0] wr_beats,
  output logic              wr_line_end,
  output logic              wr_frame_done,
  output logic [SEL_W-1:0]  wr_frame_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [BEAT_W-1:0] rd_beats,
  output logic              rd_line_end,
  output logic              rd_frame_done,
  output logic [SEL_W-1:0]  rd_frame_idx
);

  logic [SLOTS*ADDR_W-1:0] base_flat;
  logic                    advance;

  assign advance = run_en && frame_sync;

  fb_base_regs #(
    .ADDR_W    (ADDR_W),
    .NUM_FRAMES(NUM_FRAMES),
    .ALIGN_LOG2(ALIGN_LOG2)
  ) base_regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .halted   (!run_en),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .base_flat(base_flat)
  );

  logic [SEL_W-1:0]  ch_idx   [NUM_CH];
  logic              ch_step  [NUM_CH];
  logic [ADDR_W-1:0] ch_addr  [NUM_CH];
  logic [BEAT_W-1:0] ch_beats [NUM_CH];
  logic              ch_lend  [NUM_CH];
  logic              ch_done  [NUM_CH];

  assign ch_step[CH_PROD] = wr_step;
  assign ch_step[CH_CONS] = rd_step;

  // Producer starts one store ahead of the consumer
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] ch_base;

    fb_frame_ring #(
      .NUM_FRAMES(NUM_FRAMES),
      .RESET_IDX ((c == CH_PROD) ? 1 : 0)
    ) ring_i (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (advance),
      .idx  (ch_idx[c])
    );

    assign ch_base = base_flat[ch_idx[c]*ADDR_W +: ADDR_W];

    fb_line_walker #(
      .ADDR_W     (ADDR_W),
      .LINE_BYTES (LINE_BYTES),
      .STRIDE_LOG2(STRIDE_LOG2),
      .LINES      (LINES),
      .BURST_BYTES(BURST_BYTES),
      .BEAT_BYTES (BEAT_BYTES)
    ) walker_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_en),
      .restart   (advance),
      .step      (ch_step[c]),
      .base      (ch_base),
      .addr      (ch_addr[c]),
      .beats     (ch_beats[c]),
      .line_end  (ch_lend[c]),
      .frame_done(ch_done[c])
    );
  end

  assign wr_addr       = ch_addr[CH_PROD];
  assign wr_beats      = ch_beats[CH_PROD];
  assign wr_line_end   = ch_lend[CH_PROD];
  assign wr_frame_done = ch_done[CH_PROD];
  assign wr_frame_idx  = ch_idx[CH_PROD];
  assign rd_addr       = ch_addr[CH_CONS];
  assign rd_beats      = ch_beats[CH_CONS];
  assign rd_line_end   = ch_lend[CH_CONS];
  assign rd_frame_done = ch_done[CH_CONS];
  assign rd_frame_idx  = ch_idx[CH_CONS];

endmodule

// File: rtl/fb_addr_seq_chk.sv
module fb_addr_seq_chk #(
  parameter int ADDR_W      = 32,
  parameter int NUM_FRAMES  = 3,
  parameter int ALIGN_LOG2  = 24,
  parameter int LINE_BYTES  = 7680,
  parameter int STRIDE_LOG2 = 13,
  parameter int BURST_BYTES = 128,
  parameter int SEL_W       = 2,
  parameter int BEAT_W      = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              frame_sync,
  input logic              wr_step,
  input logic              rd_step,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BEAT_W-1:0] wr_beats,
  input logic              wr_frame_done,
  input logic [SEL_W-1:0]  wr_frame_idx,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_frame_done,
  input logic [SEL_W-1:0]  rd_frame_idx
);

  function automatic logic [SEL_W-1:0] ring_inc(input logic [SEL_W-1:0] v);
    return (v == SEL_W'(NUM_FRAMES - 1)) ? '0 : v + 1'b1;
  endfunction

  // R3: consumer one store behind producer
  assert_read_lags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ring_inc(rd_frame_idx) == wr_frame_idx);

  // R2: index stays inside the ring
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frame_idx < SEL_W'(NUM_FRAMES));

  // R2: sync while running advances the producer index
  assert_sync_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && frame_sync) |=> wr_frame_idx == ring_inc($past(wr_frame_idx)));

  // R4: sync restarts both channels at a store base
  assert_sync_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && frame_sync) |=> (wr_addr[ALIGN_LOG2-1:0] == '0) &&
                               (rd_addr[ALIGN_LOG2-1:0] == '0) &&
                               !wr_frame_done && !rd_frame_done);

  // R5: offset inside a line stays within payload on a burst grid
  assert_in_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr[STRIDE_LOG2-1:0] < STRIDE_LOG2'(LINE_BYTES)) &&
    (wr_addr[STRIDE_LOG2-1:0] % STRIDE_LOG2'(BURST_BYTES) == '0));

  // R6: burst length never zero nor above the maximum
  assert_beats_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_beats != '0) && (wr_beats <= BEAT_W'(BURST_BYTES / 4)));

  // R7: a finished frame holds its address until sync
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !frame_sync && wr_frame_done) |=> $stable(wr_addr) && wr_frame_done);

  // R9: halted sequencer keeps both indices
  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(wr_frame_idx) && $stable(rd_frame_idx));

  // R10: a consumer step alone never moves the producer
  assert_independent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !frame_sync && !wr_step && rd_step) |=> $stable(wr_addr));

endmodule

bind fb_addr_seq fb_addr_seq_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_FRAMES (NUM_FRAMES),
  .ALIGN_LOG2 (ALIGN_LOG2),
  .LINE_BYTES (LINE_BYTES),
  .STRIDE_LOG2(STRIDE_LOG2),
  .BURST_BYTES(BURST_BYTES),
  .SEL_W      (SEL_W),
  .BEAT_W     (BEAT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_en       (run_en),
  .frame_sync   (frame_sync),
  .wr_step      (wr_step),
  .rd_step      (rd_step),
  .wr_addr      (wr_addr),
  .wr_beats     (wr_beats),
  .wr_frame_done(wr_frame_done),
  .wr_frame_idx (wr_frame_idx),
  .rd_addr      (rd_addr),
  .rd_frame_done(rd_frame_done),
  .rd_frame_idx (rd_frame_idx)
);

// File: tb/fb_addr_seq_tb.sv
module fb_addr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW     = 32;
  localparam int ALIGN  = 12;
  localparam int LBYTES = 320;
  localparam int SLOG2  = 9;
  localparam int NLINES = 3;
  localparam int BURST  = 128;

  logic          clk;
  logic          rst_n;
  logic          run_en;
  logic          frame_sync;
  logic          cfg_we;
  logic [1:0]    cfg_sel;
  logic [AW-1:0] cfg_data;
  logic          wr_step;
  logic          rd_step;
  logic [AW-1:0] wr_addr;
  logic [5:0]    wr_beats;
  logic          wr_line_end;
  logic          wr_frame_done;
  logic [1:0]    wr_frame_idx;
  logic [AW-1:0] rd_addr;
  logic [5:0]    rd_beats;
  logic          rd_line_end;
  logic          rd_frame_done;
  logic [1:0]    rd_frame_idx;

  fb_addr_seq #(
    .ADDR_W(AW), .NUM_FRAMES(3), .ALIGN_LOG2(ALIGN), .LINE_BYTES(LBYTES),
    .STRIDE_LOG2(SLOG2), .LINES(NLINES), .BURST_BYTES(BURST), .BEAT_BYTES(4)
  ) dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model state (index 0 producer, 1 consumer)
  int           m_idx  [2];
  int           m_line [2];
  int           m_off  [2];
  bit           m_done [2];
  logic [AW-1:0] m_base [3];

  task automatic check(input string tag, input string ph, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s): actual %0h expected %0h", tag, ph, act, exp);
    end
  endtask

  task automatic compare_all(input string ph);
    for (int c = 0; c < 2; c++) begin
      longint ea;
      int rem;
      rem = LBYTES - m_off[c];
      ea = m_base[m_idx[c]] + m_line[c] * (1 << SLOG2) + m_off[c];
      if (c == 0) begin
        check("R2 wr idx", ph, wr_frame_idx, m_idx[0]);
        check("R5 wr addr", ph, wr_addr, ea);
        check("R6 wr beats", ph, wr_beats, ((rem < BURST) ? rem : BURST) / 4);
        check("R6 wr line_end", ph, wr_line_end, rem <= BURST);
        check("R7 wr done", ph, wr_frame_done, m_done[0]);
      end else begin
        check("R3 rd idx", ph, rd_frame_idx, m_idx[1]);
        check("R5 rd addr", ph, rd_addr, ea);
        check("R6 rd beats", ph, rd_beats, ((rem < BURST) ? rem : BURST) / 4);
        check("R6 rd line_end", ph, rd_line_end, rem <= BURST);
        check("R7 rd done", ph, rd_frame_done, m_done[1]);
      end
    end
  endtask

  task automatic cycle(input bit run, input bit fs, input bit ws, input bit rs,
                       input bit we, input int sel, input logic [AW-1:0] data,
                       input string ph);
    bit st [2];
    @(negedge clk);
    run_en = run; frame_sync = fs; wr_step = ws; rd_step = rs;
    cfg_we = we; cfg_sel = 2'(sel); cfg_data = data;
    @(posedge clk);
    st[0] = ws; st[1] = rs;
    if (we && !run && sel < 3 && data[ALIGN-1:0] == '0) m_base[sel] = data;
    for (int c = 0; c < 2; c++) begin
      if (!run || fs) begin
        if (run) m_idx[c] = (m_idx[c] + 1) % 3;
        m_line[c] = 0; m_off[c] = 0; m_done[c] = 0;
      end else if (st[c] && !m_done[c]) begin
        if (m_off[c] + BURST >= LBYTES) begin
          if (m_line[c] == NLINES - 1) m_done[c] = 1;
          else begin m_line[c]++; m_off[c] = 0; end
        end else m_off[c] += BURST;
      end
    end
    #1;
    compare_all(ph);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 0; frame_sync = 0; wr_step = 0; rd_step = 0;
    cfg_we = 0; cfg_sel = 0; cfg_data = '0;
    m_idx[0] = 1; m_idx[1] = 0;
    for (int c = 0; c < 2; c++) begin m_line[c] = 0; m_off[c] = 0; m_done[c] = 0; end
    for (int i = 0; i < 3; i++) m_base[i] = '0;
    #(CLK_PERIOD * 3);
    // R1: reset state
    check("R1 wr idx", "reset", wr_frame_idx, 1);
    check("R1 rd idx", "reset", rd_frame_idx, 0);
    check("R1 wr addr", "reset", wr_addr, 0);
    check("R1 rd addr", "reset", rd_addr, 0);
    check("R1 done", "reset", {wr_frame_done, rd_frame_done}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R8: legal halted writes, then illegal ones
    cycle(0, 0, 0, 0, 1, 0, 32'h0001_1000, "R8 base0");
    cycle(0, 0, 0, 0, 1, 1, 32'h0002_2000, "R8 base1");
    cycle(0, 0, 0, 0, 1, 2, 32'h0003_3000, "R8 base2");
    cycle(0, 0, 0, 0, 1, 0, 32'h0005_5800, "R8 misaligned");
    cycle(0, 0, 0, 0, 1, 3, 32'h0007_7000, "R8 sel3");
    cycle(1, 0, 0, 0, 1, 1, 32'h0009_9000, "R8 while running");

    // R6 R7 R10: producer walks whole frame alone
    for (int i = 0; i < 11; i++) cycle(1, 0, 1, 0, 0, 0, '0, "R10 wr walk");
    cycle(1, 1, 0, 0, 0, 0, '0, "R2 sync");
    for (int i = 0; i < 11; i++) cycle(1, 0, 0, 1, 0, 0, '0, "R10 rd walk");
    // R4: sync mid-frame, then back-to-back syncs around the ring
    for (int i = 0; i < 4; i++) cycle(1, 0, 1, 1, 0, 0, '0, "R4 partial");
    for (int i = 0; i < 4; i++) cycle(1, 1, 1, 1, 0, 0, '0, "R4 back2back");
    // R9: halt ignores sync and steps; base rewrite allowed
    cycle(1, 0, 1, 1, 0, 0, '0, "R9 pre");
    for (int i = 0; i < 3; i++) cycle(0, 1, 1, 1, 0, 0, '0, "R9 halted");
    cycle(0, 0, 0, 0, 1, 2, 32'h000A_A000, "R8 rewrite");
    // Cadence sweep
    for (int f = 0; f < 6; f++) begin
      for (int k = 0; k < 14; k++)
        cycle(1, 0, (k % (f % 3 + 1)) == 0, (k % 2) == (f % 2), 0, 0, '0, "sweep");
      cycle(1, 1, f[0], 1, 0, 0, '0, "R2 sweep sync");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule